// File: doc/BRIEF.md
# I2C Target Register-Access Controller

This block is the target side of an I2C link. It lets an external controller read and write a small bank of 8-bit registers through a byte-wide register pointer. SCL and SDA are sampled on the system clock through two-flop synchronizers. START, repeated START and STOP are found on the synchronized lines. The block decodes the 7-bit target address and the R/W bit, and it pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

The register bank sits outside the block, behind a plain port that carries an address, write data, a single-cycle write strobe and combinational read data. The register pointer lives inside the block and is kept across transactions. The controller has three ways to use it:
- A write sets the pointer with its first data byte and then stores any further bytes at consecutive offsets.
- A write that carries only the offset byte sets where the next read begins.
- A read, whether direct or after a repeated START, sends bytes from the pointer onward. The pointer advances after every byte sent, even when the controller does not acknowledge that byte.

Top module: `i2c_regtarget`

## Requirements
- R1: After a START, the target compares the first 7 bits with TARGET_ADDR. The 8th bit gives the direction: 0 is write, 1 is read. On a match the target acknowledges by driving SDA low on the 9th clock. On a mismatch it leaves SDA released and ignores the bus, including later bytes, until the next START or STOP.
- R2: In a write, the first byte after the address loads the pointer. Every later byte is presented on reg_wdata with reg_addr equal to the pointer and a one-cycle reg_we, and the pointer then advances by one. Every byte of a write is acknowledged.
- R3: A write made of the address and the offset byte only, followed by STOP, sets the offset at which a later separate read begins.
- R4: A read that follows an offset write through a repeated START returns data starting at that offset.
- R5: The pointer is 00h after reset. A read with no offset write before it starts at the register after the last byte read.
- R6: Read bytes are sent MSB first. After each byte the target releases SDA and samples the controller's bit on the 9th clock. A low bit (ACK) makes it send the next register. A high bit (NACK) makes it release SDA and send nothing more until START or STOP.
- R7: During a read the pointer advances after every byte sent, including a byte the controller answered with NACK.
- R8: The pointer advances from NREGS-1, or from any offset at or above it, to 00h.
- R9: A write byte at an offset of NREGS or above is acknowledged but raises no reg_we. A read at such an offset returns 00h.
- R10: sda_oe (1 = pull SDA low) changes only while the synchronized SCL is low, and it is 0 after a STOP.
- R11: A START in the middle of a byte abandons that byte and restarts the bit count, so a complete address following it is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 8 | Register pointer, used as the register-file address |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | One-cycle write strobe for an in-range register |
| reg_rdata | input | 8 | Read data for reg_addr (combinational) |

## Verification
The assertions assume a well-behaved controller:
- SCL stays low and high for more than the synchronizer delay, so each edge reaches the logic while the line still holds its new level.
- START and STOP are issued only while the target has SDA released.

The bench controller keeps six system clocks between every SCL or SDA change. It always ends a read with a NACK before it sends STOP. It raises a repeated START only after an acknowledge bit, or in the middle of a byte it is driving itself. Under these conditions, the SDA-enable and pointer-step properties cover every transaction.

// File: rtl/i2c_regtarget.sv
module i2c_regtarget #(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int         NREGS       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam logic [7:0] LAST = 8'(NREGS - 1);
  localparam logic [8:0] NR9  = 9'(NREGS);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_OFFS, S_OACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_RNXT
  } st_t;

  st_t        st;
  logic [2:0] scl_sy, sda_sy, bitcnt;
  logic [7:0] ptr, sr, tx;
  logic       rw, ackph;

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_sy[1];
  assign scl_q = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_q = sda_sy[2];

  wire start_c   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  wire rise      = scl_s & ~scl_q;
  wire fall      = ~scl_s & scl_q;
  wire byte_done = rise && (bitcnt == 3'd7);
  wire in_range  = ({1'b0, ptr} < NR9);
  wire [7:0] rx      = {sr[6:0], sda_s};
  wire [7:0] ptr_inc = (ptr >= LAST) ? 8'd0 : ptr + 8'd1;
  wire [7:0] rd_byte = in_range ? reg_rdata : 8'd0;

  assign reg_addr  = ptr;
  assign reg_wdata = rx;
  assign reg_we    = (st == S_WDAT) && byte_done && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
      st     <= S_IDLE;
      ptr    <= '0;
      sr     <= '0;
      tx     <= '0;
      bitcnt <= '0;
      rw     <= 1'b0;
      ackph  <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      if (start_c) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        ackph  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_OFFS, S_WDAT: if (rise) begin
            sr     <= rx;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              ackph <= 1'b0;
              if (st == S_ADDR) begin
                if (rx[7:1] == TARGET_ADDR) begin
                  rw <= rx[0];
                  st <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_OFFS) begin
                ptr <= rx;
                st  <= S_OACK;
              end else begin
                ptr <= ptr_inc;
                st  <= S_WACK;
              end
            end
          end
          S_AACK, S_OACK, S_WACK: if (fall) begin
            if (!ackph) begin
              ackph  <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ackph  <= 1'b0;
              bitcnt <= '0;
              if (st == S_AACK && rw) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                st     <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= (st == S_AACK) ? S_OFFS : S_WDAT;
              end
            end
          end
          S_RDAT: begin
            if (rise) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                ptr <= ptr_inc;
                st  <= S_RACK;
              end
            end else if (fall) begin
              tx     <= tx << 1;
              sda_oe <= ~tx[6];
            end
          end
          S_RACK: begin
            if (fall) sda_oe <= 1'b0;
            else if (rise) st <= sda_s ? S_IDLE : S_RNXT;
          end
          S_RNXT: if (fall) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            bitcnt <= '0;
            st     <= S_RDAT;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regtarget_chk.sv
module i2c_regtarget_chk #(
  parameter int NREGS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_q,
  input logic       sda_s,
  input logic       sda_q,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr
);
  localparam logic [7:0] LAST = 8'(NREGS - 1);
  localparam logic [8:0] NR9  = 9'(NREGS);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !sda_q && sda_s) |=> !sda_oe);

  // R9
  oor_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ({1'b0, reg_addr} < NR9));

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == (($past(reg_addr) >= LAST) ? 8'd0 : $past(reg_addr) + 8'd1));
endmodule

bind i2c_regtarget i2c_regtarget_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s),
  .sda_q(sda_q), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/sim_i2c_regtarget.sv
`timescale 1ns/1ps
module sim_i2c_regtarget;
  localparam logic [6:0] TADDR = 7'h2A;
  localparam logic [6:0] BADDR = 7'h2B;
  localparam int NREGS = 16;
  localparam int AW = $clog2(NREGS);
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic bus_sda;

  always #10 clk = ~clk;
  assign bus_sda = sda_drv & ~sda_oe;

  i2c_regtarget #(.TARGET_ADDR(TADDR), .NREGS(NREGS)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(bus_sda), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  logic [7:0] rf [NREGS];
  logic [7:0] exp_mem [NREGS];
  logic [7:0] exp_ptr;
  int we_cnt = 0, nvec = 0, nfail = 0;
  bit done = 0;

  assign reg_rdata = (reg_addr < NREGS) ? rf[reg_addr[AW-1:0]] : 8'hA5;
  always @(posedge clk) if (reg_we) begin
    we_cnt <= we_cnt + 1;
    if (reg_addr < NREGS) rf[reg_addr[AW-1:0]] <= reg_wdata;
  end

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p >= NREGS - 1) ? 8'd0 : p + 8'd1;
  endfunction
  function automatic logic [7:0] expect_rd(input logic [7:0] p);
    return (p < NREGS) ? exp_mem[p[AW-1:0]] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic send_bit(input logic b);
    sda_drv = b; tick(Q); scl_drv = 1'b1; tick(2*Q); scl_drv = 1'b0; tick(Q);
  endtask
  task automatic read_bit(output logic b);
    sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q); b = bus_sda; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask
  task automatic do_start;
    sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q); sda_drv = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask
  task automatic do_stop;
    sda_drv = 1'b0; tick(Q); scl_drv = 1'b1; tick(Q); sda_drv = 1'b1; tick(2*Q);
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(a);
    ack = ~a;
  endtask
  task automatic rd_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(~ack);
  endtask

  task automatic t_write(input logic [7:0] off, input int n, input string tag);
    logic ack; logic [7:0] d;
    do_start;
    wr_byte({TADDR, 1'b0}, ack); chk("R1 addr ack", ack, 1);
    wr_byte(off, ack); chk({tag, " offset ack"}, ack, 1);
    exp_ptr = off;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wr_byte(d, ack); chk({tag, " data ack"}, ack, 1);
      if (exp_ptr < NREGS) exp_mem[exp_ptr[AW-1:0]] = d;
      exp_ptr = nxt(exp_ptr);
    end
    do_stop;
  endtask

  task automatic t_read(input bit rs, input logic [7:0] off, input int n,
                        input bit idle_chk, input string tag);
    logic ack; logic [7:0] d;
    do_start;
    if (rs) begin
      wr_byte({TADDR, 1'b0}, ack); chk("R1 addr ack", ack, 1);
      wr_byte(off, ack); chk("R4 offset ack", ack, 1);
      exp_ptr = off;
      do_start;
    end
    wr_byte({TADDR, 1'b1}, ack); chk("R1 read addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(d, k != n - 1);
      chk({tag, " read data"}, d, expect_rd(exp_ptr));
      exp_ptr = nxt(exp_ptr);
    end
    if (idle_chk) begin
      for (int i = 7; i >= 0; i--) read_bit(d[i]);
      chk("R6 released after NACK", d, 8'hFF);
    end
    do_stop;
    chk("R10 oe low after stop", sda_oe, 0);
  endtask

  task automatic t_bad;
    logic ack; int w0;
    w0 = we_cnt;
    do_start;
    wr_byte({BADDR, 1'b0}, ack); chk("R1 mismatch nack", ack, 0);
    wr_byte(8'h03, ack); chk("R1 ignored byte nack", ack, 0);
    wr_byte(8'h5C, ack); chk("R1 ignored byte nack", ack, 0);
    do_stop;
    chk("R1 no strobe on mismatch", we_cnt, w0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREGS; i++) begin
      rf[i] = 8'($urandom); exp_mem[i] = rf[i];
    end
    exp_ptr = 8'd0;
    tick(5); rst_n = 1'b1; tick(3);
    chk("R5 reset pointer", reg_addr, 0);
    chk("R10 reset oe", sda_oe, 0);
    chk("R2 reset strobe", reg_we, 0);

    t_read(0, 0, 2, 0, "R5");
    t_read(0, 0, 1, 0, "R5");
    t_write(8'd3, 3, "R2");
    t_read(1, 8'd3, 3, 1, "R4");
    t_write(8'd9, 0, "R3");
    t_read(0, 0, 2, 0, "R3");
    t_read(0, 0, 2, 0, "R7");
    t_write(8'd14, 4, "R8");
    t_read(1, 8'd14, 4, 0, "R8");
    w0 = we_cnt;
    t_write(8'h30, 2, "R9");
    chk("R9 one strobe only", we_cnt, w0 + 1);
    t_write(8'h40, 0, "R9");
    t_read(0, 0, 2, 0, "R9");
    t_bad;
    t_read(0, 0, 1, 0, "R1");
    do_start;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    t_read(0, 0, 2, 0, "R11");

    for (int t = 0; t < 45; t++) begin
      case ($urandom_range(0, 4))
        0: t_write(8'($urandom_range(0, 19)), $urandom_range(0, 4), "R2");
        1: t_write(8'($urandom_range(0, 15)), 0, "R3");
        2: t_read(1, 8'($urandom_range(0, 19)), $urandom_range(1, 4), 0, "R4");
        3: t_read(0, 0, $urandom_range(1, 4), 0, "R5");
        default: t_bad;
      endcase
    end
    t_read(1, 8'd0, NREGS, 1, "R2");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule